// File: doc/BRIEF.md
# Flash Interrupt and Command Register

This block is the register slice of a NAND-style flash controller that sits between a host bus and a command executor. The host reads and writes 16-bit registers by offset. Writing the command register hands a command code to the executor as a one-cycle strobe. The executor reports back with completion and error pulses, and these set flags in the interrupt and controller status registers.

The block refuses new commands while the main interrupt flag is set. The host clears interrupt bits by writing a mask that is ANDed into the register. Clearing the main flag also wipes the four error bits in the status register. Two reset commands restore the register state without a pin reset. The interrupt pin polarity and the ready output come from bits of configuration register 1.

Top module: `flash_cmd_int_regs`

## Requirements
- R1: After the `rst_n` pin reset the registers read as follows: command 0x0000, configuration 1 0x40C0, configuration 2 0x0000, status 0x0000 and interrupt 0x8080. `rdy` is 1. The register offsets are: 0 command, 1 configuration 1, 2 configuration 2, 3 status (read-only), 4 interrupt. Any other offset reads 0.
- R2: A host write to the interrupt register (offset 4) replaces it with the old value ANDed with the written data.
- R3: If bit 15 of the interrupt register is clear after that AND, status bits 13 down to 10 are cleared in the same cycle.
- R4: A write to the command register (offset 0) while interrupt bit 15 is set changes nothing: the command register keeps its value and no strobe is issued.
- R5: An accepted write of a known command stores the value. In the next cycle it raises `cmd_valid` for exactly one cycle, with `cmd_code` holding the low byte. The known codes are 0x00, 0x13, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x30, 0x65, 0x71, 0x80, 0x94, 0x95 and 0xB0, each with a zero upper byte.
- R6: An accepted write of any other code (apart from 0xF0 and 0xF3) sets status bit 10 and interrupt bit 15, and issues no strobe.
- R7: An `exe_done` pulse sets interrupt bit 15 together with a completion bit chosen by `exe_kind`: 0 = erase, bit 5; 1 = program, bit 6; 2 = load, bit 7; 3 = bit 15 only.
- R8: An `exe_err` pulse sets status bit 10 together with an error bit chosen by `exe_kind`: 0 = erase, bit 11; 1 = program, bit 12; 2 = load, bit 13; 3 = bit 10 only.
- R9: Pulses that arrive in the same cycle all take effect in that cycle. A done pulse and an error pulse are both recorded. When a host interrupt write coincides with a pulse, the AND and the status wipe are applied first and the pulse bits are then set on top.
- R10: An accepted command 0xF0 or 0xF3 performs a warm reset, which issues no strobe. The command register becomes 0x0000, configuration 1 becomes 0x40C0, configuration 2 and status become 0x0000, the interrupt register becomes 0x8010 and `rdy` becomes 1.
- R11: `irq` equals interrupt bit 15 XOR the inverse of configuration 1 bit 6.
- R12: Configuration 1 reads back as the stored value ANDed with 0xFFE0.
- R13: `rdy` takes configuration 1 bit 7 on the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| bus_we | input | 1 | Host write enable |
| bus_addr | input | ADDR_W | Register offset for reads and writes |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_code | output | 8 | Command code that goes with the strobe |
| exe_done | input | 1 | Executor completion pulse |
| exe_err | input | 1 | Executor error pulse |
| exe_kind | input | 2 | Operation class of the pulse: 0 erase, 1 program, 2 load |
| irq | output | 1 | Interrupt pin, polarity set by configuration 1 bit 6 |
| rdy | output | 1 | Ready output, follows configuration 1 bit 7 |

## Verification
Every register effect of a write or a pulse lands on the same clock edge that samples it. Read data is combinational, so a new value is visible one edge after the stimulus, and that includes `irq`. `cmd_valid` and `cmd_code` are due in the cycle that follows the accepting edge. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge. It compares read data, strobe, code, `irq` and `rdy` 1 ns after every rising edge, so every result is checked in exactly the cycle it is due.

// File: rtl/flash_cmd_int_regs.sv
module flash_cmd_int_regs #(
  parameter int ADDR_W   = 3,
  parameter int OFF_CMD  = 0,
  parameter int OFF_CFG1 = 1,
  parameter int OFF_CFG2 = 2,
  parameter int OFF_STAT = 3,
  parameter int OFF_INT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              cmd_valid,
  output logic [7:0]        cmd_code,
  input  logic              exe_done,
  input  logic              exe_err,
  input  logic [1:0]        exe_kind,
  output logic              irq,
  output logic              rdy
);
  localparam logic [15:0] CFG1_RST  = 16'h40C0;
  localparam logic [15:0] INT_COLD  = 16'h8080;
  localparam logic [15:0] INT_WARM  = 16'h8010;
  localparam logic [15:0] ERR_MASK  = 16'h3C00;
  localparam logic [15:0] CFG1_RDMK = 16'hFFE0;

  logic [15:0] cmd_q, cfg1_q, cfg2_q, stat_q, int_q;
  logic [15:0] cmd_n, cfg1_n, cfg2_n, stat_n, int_n;
  logic        rdy_n, valid_n, warm;
  logic [7:0]  code_n;

  function automatic logic is_known(input logic [15:0] v);
    if (v[15:8] != 8'h00) return 1'b0;
    case (v[7:0])
      8'h00, 8'h13, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A, 8'h2C,
      8'h30, 8'h65, 8'h71, 8'h80, 8'h94, 8'h95, 8'hB0: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  wire wr_cmd  = bus_we && (bus_addr == ADDR_W'(OFF_CMD));
  wire wr_cfg1 = bus_we && (bus_addr == ADDR_W'(OFF_CFG1));
  wire wr_cfg2 = bus_we && (bus_addr == ADDR_W'(OFF_CFG2));
  wire wr_int  = bus_we && (bus_addr == ADDR_W'(OFF_INT));
  wire cmd_ok  = wr_cmd && !int_q[15];
  wire is_rst_cmd = (bus_wdata == 16'h00F0) || (bus_wdata == 16'h00F3);

  always_comb begin
    cmd_n   = cmd_q;
    cfg1_n  = cfg1_q;
    cfg2_n  = cfg2_q;
    stat_n  = stat_q;
    int_n   = int_q;
    rdy_n   = rdy;
    valid_n = 1'b0;
    code_n  = cmd_code;
    warm    = 1'b0;
    if (cmd_ok) begin
      cmd_n = bus_wdata;
      if (is_rst_cmd) warm = 1'b1;
      else if (is_known(bus_wdata)) begin
        valid_n = 1'b1;
        code_n  = bus_wdata[7:0];
      end else begin
        stat_n[10] = 1'b1;
        int_n[15]  = 1'b1;
      end
    end
    if (wr_cfg1) begin
      cfg1_n = bus_wdata;
      rdy_n  = bus_wdata[7];
    end
    if (wr_cfg2) cfg2_n = bus_wdata;
    if (wr_int) begin
      int_n = int_q & bus_wdata;
      if (!int_n[15]) stat_n = stat_n & ~ERR_MASK;
    end
    if (warm) begin
      cmd_n  = '0;
      cfg1_n = CFG1_RST;
      cfg2_n = '0;
      stat_n = '0;
      int_n  = INT_WARM;
      rdy_n  = 1'b1;
    end
    if (exe_done) begin
      int_n[15] = 1'b1;
      case (exe_kind)
        2'd0: int_n[5] = 1'b1;
        2'd1: int_n[6] = 1'b1;
        2'd2: int_n[7] = 1'b1;
        default: ;
      endcase
    end
    if (exe_err) begin
      stat_n[10] = 1'b1;
      case (exe_kind)
        2'd0: stat_n[11] = 1'b1;
        2'd1: stat_n[12] = 1'b1;
        2'd2: stat_n[13] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      cfg1_q    <= CFG1_RST;
      cfg2_q    <= '0;
      stat_q    <= '0;
      int_q     <= INT_COLD;
      rdy       <= 1'b1;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
    end else begin
      cmd_q     <= cmd_n;
      cfg1_q    <= cfg1_n;
      cfg2_q    <= cfg2_n;
      stat_q    <= stat_n;
      int_q     <= int_n;
      rdy       <= rdy_n;
      cmd_valid <= valid_n;
      cmd_code  <= code_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == ADDR_W'(OFF_CMD))  bus_rdata = cmd_q;
    else if (bus_addr == ADDR_W'(OFF_CFG1)) bus_rdata = cfg1_q & CFG1_RDMK;
    else if (bus_addr == ADDR_W'(OFF_CFG2)) bus_rdata = cfg2_q;
    else if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata = stat_q;
    else if (bus_addr == ADDR_W'(OFF_INT))  bus_rdata = int_q;
  end

  assign irq = int_q[15] ^ ~cfg1_q[6];

  a_r4_strobe_needs_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(!int_q[15] && wr_cmd));

  a_r5_strobe_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_ok && is_known(bus_wdata)) |-> (cmd_valid && cmd_code == $past(bus_wdata[7:0])));

  a_r6_unknown_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_ok && !is_rst_cmd && !is_known(bus_wdata)) |-> (stat_q[10] && int_q[15] && !cmd_valid));

  a_r3_clear_wipes_errors: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_int && !exe_err) && !int_q[15]) |-> (stat_q[13:10] == 4'b0000));

  a_r7_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exe_done) |-> int_q[15]);

  a_r13_rdy_tracks_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_cfg1) |-> (rdy == $past(bus_wdata[7])));
endmodule

// File: tb/flash_cmd_int_regs_test.sv
module flash_cmd_int_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cmd_valid;
  logic [7:0]  cmd_code;
  logic        exe_done = 1'b0, exe_err = 1'b0;
  logic [1:0]  exe_kind = '0;
  logic        irq, rdy;

  int tests = 0, fails = 0;
  bit done_flag = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  flash_cmd_int_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .exe_done(exe_done), .exe_err(exe_err),
    .exe_kind(exe_kind), .irq(irq), .rdy(rdy));

  // behavioural reference model
  logic [15:0] m_cmd, m_cfg1, m_cfg2, m_stat, m_int;
  logic        m_rdy, m_cv;
  logic [7:0]  m_code;

  function automatic bit known(input logic [15:0] v);
    logic [7:0] list [15] = '{8'h00, 8'h13, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A,
                              8'h2C, 8'h30, 8'h65, 8'h71, 8'h80, 8'h94, 8'h95, 8'hB0};
    if (v[15:8] != 0) return 0;
    foreach (list[i]) if (list[i] == v[7:0]) return 1;
    return 0;
  endfunction

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cmd;
      3'd1: return m_cfg1 & 16'hFFE0;
      3'd2: return m_cfg2;
      3'd3: return m_stat;
      3'd4: return m_int;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_cfg1 = 16'h40C0; m_cfg2 = 0; m_stat = 0; m_int = 16'h8080;
      m_rdy = 1; m_cv = 0; m_code = 0;
    end else begin
      bit pend;
      pend = m_int[15];
      m_cv = 0;
      if (bus_we) begin
        if (bus_addr == 0 && !pend) begin
          m_cmd = bus_wdata;
          if (bus_wdata == 16'h00F0 || bus_wdata == 16'h00F3) begin
            m_cmd = 0; m_cfg1 = 16'h40C0; m_cfg2 = 0; m_stat = 0;
            m_int = 16'h8010; m_rdy = 1;
          end else if (known(bus_wdata)) begin
            m_cv = 1; m_code = bus_wdata[7:0];
          end else begin
            m_stat = m_stat | 16'h0400; m_int = m_int | 16'h8000;
          end
        end
        if (bus_addr == 1) begin m_cfg1 = bus_wdata; m_rdy = bus_wdata[7]; end
        if (bus_addr == 2) m_cfg2 = bus_wdata;
        if (bus_addr == 4) begin
          m_int = m_int & bus_wdata;
          if (!m_int[15]) m_stat = m_stat & 16'hC3FF;
        end
      end
      if (exe_done) m_int = m_int | 16'h8000 | (exe_kind == 3 ? 16'h0 : (16'h0020 << exe_kind));
      if (exe_err)  m_stat = m_stat | 16'h0400 | (exe_kind == 3 ? 16'h0 : (16'h0800 << exe_kind));
    end
  end

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done_flag) begin
      check(cur_req, "rdata", bus_rdata, m_read(bus_addr));
      check("R11", "irq", {15'd0, irq}, {15'd0, m_int[15] ^ ~m_cfg1[6]});
      check("R13", "rdy", {15'd0, rdy}, {15'd0, m_rdy});
      check("R5", "cmd_valid", {15'd0, cmd_valid}, {15'd0, m_cv});
      if (m_cv) check("R5", "cmd_code", {8'd0, cmd_code}, {8'd0, m_code});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic pulse(input bit d, input bit e, input logic [1:0] k);
    @(negedge clk); exe_done = d; exe_err = e; exe_kind = k;
    @(negedge clk); exe_done = 0; exe_err = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk); bus_addr = a;
    @(posedge clk); #1;
    check(req, "read", bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    rd("R1", 0, 16'h0000); rd("R1", 1, 16'h40C0); rd("R1", 2, 16'h0000);
    rd("R1", 3, 16'h0000); rd("R1", 4, 16'h8080); rd("R1", 6, 16'h0000);
    check("R1", "rdy", {15'd0, rdy}, 16'd1);

    cur_req = "R2";
    wr(4, 16'h00FF); rd("R2", 4, 16'h0080);

    cur_req = "R4";
    pulse(1, 0, 0); rd("R4", 4, 16'h80A0);
    wr(0, 16'h0094); rd("R4", 0, 16'h0000);
    check("R4", "no strobe", {15'd0, cmd_valid}, 16'd0);

    cur_req = "R5";
    wr(4, 16'h0000);
    @(negedge clk); bus_we = 1; bus_addr = 0; bus_wdata = 16'h0080;
    @(posedge clk); #1;
    check("R5", "strobe", {15'd0, cmd_valid}, 16'd1);
    check("R5", "code", {8'd0, cmd_code}, 16'h0080);
    @(negedge clk); bus_we = 0;
    @(posedge clk); #1;
    check("R5", "strobe one cycle", {15'd0, cmd_valid}, 16'd0);
    rd("R5", 0, 16'h0080);

    cur_req = "R6";
    wr(0, 16'h0042); rd("R6", 3, 16'h0400); rd("R6", 4, 16'h8000);

    cur_req = "R3";
    wr(4, 16'h7FFF); rd("R3", 3, 16'h0000); rd("R3", 4, 16'h0000);

    cur_req = "R8";
    pulse(1, 1, 1); rd("R8", 3, 16'h1400); rd("R9", 4, 16'h8040);
    pulse(0, 1, 2); rd("R8", 3, 16'h3400);
    pulse(0, 1, 0); rd("R8", 3, 16'h3C00);

    cur_req = "R9";
    @(negedge clk); bus_we = 1; bus_addr = 4; bus_wdata = 16'h0000;
    exe_done = 1; exe_kind = 2;
    @(negedge clk); bus_we = 0; exe_done = 0;
    rd("R9", 4, 16'h8080); rd("R9", 3, 16'h0000);

    cur_req = "R7";
    wr(4, 16'h0000); pulse(1, 0, 1); rd("R7", 4, 16'h8040);
    wr(4, 16'h0000); pulse(1, 0, 3); rd("R7", 4, 16'h8000);

    cur_req = "R12";
    wr(4, 16'h0000); wr(1, 16'hFFFF); rd("R12", 1, 16'hFFE0);

    cur_req = "R13";
    wr(1, 16'h0000);
    check("R13", "rdy low", {15'd0, rdy}, 16'd0);
    check("R11", "irq inverted idle", {15'd0, irq}, 16'd1);

    cur_req = "R10";
    wr(2, 16'h1234); wr(0, 16'h00F0);
    rd("R10", 4, 16'h8010); rd("R10", 1, 16'h40C0); rd("R10", 2, 16'h0000);
    rd("R10", 0, 16'h0000);
    check("R10", "rdy", {15'd0, rdy}, 16'd1);
    check("R11", "irq after warm", {15'd0, irq}, 16'd1);
    wr(4, 16'h0000); wr(2, 16'h0055); wr(0, 16'h00F3);
    rd("R10", 2, 16'h0000); rd("R10", 4, 16'h8010);

    repeat (3) @(negedge clk);
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done_flag) begin
      done_flag = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule